// File: doc/BRIEF.md
# Per-Flow Buffer Occupancy Flow Controller

This block keeps count of how many buffer bytes each flow holds, and how many the whole buffer holds. It tells the upstream neighbour, one flow at a time, to stop or restart sending. Each packet that enters the buffer reports its flow index and byte length on the arrival inputs. Each packet that leaves reports the same pair on the departure inputs. An arrival and a departure may occur in the same cycle.

A flow with too much data, or a buffer that is too full, makes the block issue a hold command for that flow. The upstream node both pauses the flow and moves it to a separate queue. Once both the flow and the buffer have drained far enough, the block issues a release command. The upstream node then resumes the flow and moves it back to its normal queue.

Each flow has a two-state machine that gives the commands hysteresis:
- FL_RUN is the reset state.
- The HOLD_EDGE transition goes from FL_RUN to FL_HELD and issues a hold command.
- The RELEASE_EDGE transition goes from FL_HELD back to FL_RUN and issues a release command.

A flow is evaluated only in a cycle where it is touched by an arrival or a departure. Commands go into a small queue and leave it one per cycle.

Top module: `flow_occupancy_ctrl`

## Requirements
- R1: An arrival adds `arr_bytes` to the counter of flow `arr_flow` and to the total counter. A counter saturates at its all-ones value.
- R2: A departure subtracts `dep_bytes` from the counter of flow `dep_flow` and from the total counter.
- R3: A flow in FL_RUN that is touched in a cycle leaves with a hold command (`cmd_release`=0) and goes to FL_HELD when, after that cycle's update, its counter or the total counter is at or above the present `xoff_lvl`.
- R4: A flow in FL_HELD that is touched in a cycle leaves with a release command (`cmd_release`=1) and goes to FL_RUN when, after that cycle's update, its counter and the total counter are both at or below the present `xon_lvl`.
- R5: A departure larger than the stored value (after adding any same-cycle arrival) sets that counter to 0 rather than wrapping. `err_underflow` is then high for exactly the following cycle.
- R6: A held flow gets no second hold command, and a running flow gets no release command. Levels between `xon_lvl` and `xoff_lvl` produce no command.
- R7: An arrival and a departure for the same flow in one cycle are merged into one net update, followed by one evaluation.
- R8: A command appears on the cmd outputs in the cycle after the input edge that caused it, and at most one command is shown per cycle. When two flows cross in the same cycle, both commands are queued and the arrival flow's command comes first.
- R9: A flow that is not touched keeps its state even when the total counter moves.
- R10: After reset all counters are zero, every flow is in FL_RUN, and `cmd_valid` and `err_underflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xoff_lvl | input | 20 | Hold threshold in bytes |
| xon_lvl | input | 20 | Release threshold in bytes, below xoff_lvl |
| arr_valid | input | 1 | A packet enters the buffer |
| arr_flow | input | 3 | Flow index of the entering packet |
| arr_bytes | input | 20 | Byte length of the entering packet |
| dep_valid | input | 1 | A packet leaves the buffer |
| dep_flow | input | 3 | Flow index of the leaving packet |
| dep_bytes | input | 20 | Byte length of the leaving packet |
| cmd_valid | output | 1 | A command is shown this cycle |
| cmd_release | output | 1 | 0 = hold (pause and migrate), 1 = release (resume and migrate back) |
| cmd_flow | output | 3 | Flow the command applies to |
| err_underflow | output | 1 | One-cycle pulse after a counter was clamped at zero |

## Verification
The bench builds occupancy on a single flow until it reaches exactly the hold level. It then drains the flow down to exactly the release level, which shows whether the comparisons are inclusive. Other flows are filled so that only the total counter crosses, and one flow is left untouched while the total falls. These patterns separate a crossing of the flow counter from a crossing of the total counter, and separate touched flows from untouched ones. The bench also gives the same flow an arrival and a departure in one cycle, where dropping either half changes whether a command is due. A departure is made larger than the stored value and then followed by a fill, which shows clamping rather than wrapping. Two flows are made to cross in one cycle to show the order in which their commands leave the queue.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
    typedef enum logic {
        FL_RUN  = 1'b0,
        FL_HELD = 1'b1
    } flow_st_e;

    typedef enum logic {
        CMD_HOLD    = 1'b0,
        CMD_RELEASE = 1'b1
    } cmd_kind_e;
endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] inc,
    input  logic [CNT_W-1:0] dec,
    output logic [CNT_W-1:0] cnt_d,
    output logic             uflow
);
    localparam logic [CNT_W:0] CAP = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;
    logic [CNT_W:0]   diff;

    // Net update: add the arrival, then remove the departure, clamping at both ends.
    always_comb begin
        sum   = {1'b0, cnt_q} + {1'b0, inc};
        uflow = (sum < {1'b0, dec});
        diff  = sum - {1'b0, dec};
        if (uflow)
            cnt_d = '0;
        else if (diff > CAP)
            cnt_d = '1;
        else
            cnt_d = diff[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // R5
    clamp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> (cnt_q == '0));
endmodule

// File: rtl/flow_state.sv
module flow_state
    import flowctl_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [CNT_W-1:0] tot_d,
    input  logic [CNT_W-1:0] xoff,
    input  logic [CNT_W-1:0] xon,
    input  logic             grant,
    output logic             req,
    output cmd_kind_e        req_kind
);
    flow_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FL_RUN;
        else
            state_q <= state_d;
    end

    // A transition happens only if its command was accepted into the queue.
    always_comb begin
        req      = 1'b0;
        req_kind = CMD_HOLD;
        state_d  = state_q;
        unique case (state_q)
            FL_RUN: begin
                if (touch && (cnt_d >= xoff || tot_d >= xoff)) begin
                    req = 1'b1;
                    if (grant)
                        state_d = FL_HELD;
                end
            end
            FL_HELD: begin
                if (touch && cnt_d <= xon && tot_d <= xon) begin
                    req      = 1'b1;
                    req_kind = CMD_RELEASE;
                    if (grant)
                        state_d = FL_RUN;
                end
            end
        endcase
    end

    // R3
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_HELD && $past(state_q) == FL_RUN)
            |-> $past(touch && (cnt_d >= xoff || tot_d >= xoff)));

    // R4
    release_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_RUN && $past(state_q) == FL_HELD)
            |-> $past(touch && cnt_d <= xon && tot_d <= xon));
endmodule

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        n_push,
    input  logic [DATA_W-1:0] d0,
    input  logic [DATA_W-1:0] d1,
    output logic [DATA_W-1:0] head,
    output logic              head_valid,
    output logic [$clog2(DEPTH):0] used
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [PTR_W:0]    cnt_q;
    logic              pop;

    assign pop        = (cnt_q != '0);
    assign head_valid = pop;
    assign head       = mem[rp_q];
    assign used       = cnt_q;

    always_ff @(posedge clk) begin
        if (n_push != 2'd0)
            mem[wp_q] <= d0;
        if (n_push == 2'd2)
            mem[wp_q + 1'b1] <= d1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_q + PTR_W'(n_push);
            rp_q  <= rp_q + PTR_W'(pop);
            cnt_q <= cnt_q + (PTR_W+1)'(n_push) - (PTR_W+1)'(pop);
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) + int'(n_push) - int'(pop)) <= DEPTH);
endmodule

// File: rtl/flow_occupancy_ctrl.sv
module flow_occupancy_ctrl
    import flowctl_pkg::*;
#(
    parameter int NUM_FLOWS = 8,
    parameter int CNT_W     = 20,
    parameter int QDEPTH    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             xoff_lvl,
    input  logic [CNT_W-1:0]             xon_lvl,
    input  logic                         arr_valid,
    input  logic [$clog2(NUM_FLOWS)-1:0] arr_flow,
    input  logic [CNT_W-1:0]             arr_bytes,
    input  logic                         dep_valid,
    input  logic [$clog2(NUM_FLOWS)-1:0] dep_flow,
    input  logic [CNT_W-1:0]             dep_bytes,
    output logic                         cmd_valid,
    output logic                         cmd_release,
    output logic [$clog2(NUM_FLOWS)-1:0] cmd_flow,
    output logic                         err_underflow
);
    localparam int FLOW_W = $clog2(NUM_FLOWS);
    localparam int CMD_W  = FLOW_W + 1;

    logic [CNT_W-1:0]     tot_inc, tot_dec, tot_d;
    logic                 tot_uf;
    logic [NUM_FLOWS-1:0] flow_uf, req_v, grant_v;
    cmd_kind_e            kind_v [NUM_FLOWS];

    assign tot_inc = arr_valid ? arr_bytes : '0;
    assign tot_dec = dep_valid ? dep_bytes : '0;

    occ_counter #(.CNT_W(CNT_W)) u_total (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tot_inc),
        .dec   (tot_dec),
        .cnt_d (tot_d),
        .uflow (tot_uf)
    );

    for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
        logic             hit_arr, hit_dep;
        logic [CNT_W-1:0] inc_f, dec_f, cnt_f;

        assign hit_arr = arr_valid && (arr_flow == FLOW_W'(f));
        assign hit_dep = dep_valid && (dep_flow == FLOW_W'(f));
        assign inc_f   = hit_arr ? arr_bytes : '0;
        assign dec_f   = hit_dep ? dep_bytes : '0;

        occ_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_f),
            .dec   (dec_f),
            .cnt_d (cnt_f),
            .uflow (flow_uf[f])
        );

        flow_state #(.CNT_W(CNT_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .touch    (hit_arr || hit_dep),
            .cnt_d    (cnt_f),
            .tot_d    (tot_d),
            .xoff     (xoff_lvl),
            .xon      (xon_lvl),
            .grant    (grant_v[f]),
            .req      (req_v[f]),
            .req_kind (kind_v[f])
        );
    end

    // Only touched flows can request: the arrival flow first, then a distinct departure flow.
    logic             req_a, req_b, dep_sep, g_a, g_b, head_valid;
    logic [CMD_W-1:0] ent_a, ent_b, d0, head;
    logic [1:0]       n_push;
    logic [$clog2(QDEPTH):0] used;
    int               free_slots;

    assign dep_sep    = dep_valid && !(arr_valid && dep_flow == arr_flow);
    assign req_a      = arr_valid && req_v[arr_flow];
    assign req_b      = dep_sep && req_v[dep_flow];
    assign ent_a      = {kind_v[arr_flow], arr_flow};
    assign ent_b      = {kind_v[dep_flow], dep_flow};
    assign free_slots = QDEPTH - int'(used) + int'(head_valid);
    assign g_a        = req_a && (free_slots >= 1);
    assign g_b        = req_b && (free_slots >= (g_a ? 2 : 1));
    assign n_push     = 2'(g_a) + 2'(g_b);
    assign d0         = g_a ? ent_a : ent_b;

    for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_grant
        assign grant_v[f] = (g_a && arr_flow == FLOW_W'(f)) ||
                            (g_b && dep_flow == FLOW_W'(f));
    end

    cmd_fifo #(.DEPTH(QDEPTH), .DATA_W(CMD_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .n_push     (n_push),
        .d0         (d0),
        .d1         (ent_b),
        .head       (head),
        .head_valid (head_valid),
        .used       (used)
    );

    assign cmd_valid   = head_valid;
    assign cmd_release = head[CMD_W-1];
    assign cmd_flow    = head[FLOW_W-1:0];

    logic err_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= tot_uf || (|flow_uf);
    end
    assign err_underflow = err_q;

    // R5
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> $past(dep_valid));
endmodule

// File: tb/flow_occupancy_ctrl_tb.sv
module flow_occupancy_ctrl_tb;
    localparam int  NF  = 8;
    localparam longint CAP = (64'd1 << 20) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] xoff_lvl = 20'd1000, xon_lvl = 20'd400;
    logic        arr_valid = 1'b0, dep_valid = 1'b0;
    logic [2:0]  arr_flow = '0, dep_flow = '0;
    logic [19:0] arr_bytes = '0, dep_bytes = '0;
    logic        cmd_valid, cmd_release, err_underflow;
    logic [2:0]  cmd_flow;

    always #4 clk = ~clk;

    flow_occupancy_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .xoff_lvl(xoff_lvl), .xon_lvl(xon_lvl),
        .arr_valid(arr_valid), .arr_flow(arr_flow), .arr_bytes(arr_bytes),
        .dep_valid(dep_valid), .dep_flow(dep_flow), .dep_bytes(dep_bytes),
        .cmd_valid(cmd_valid), .cmd_release(cmd_release), .cmd_flow(cmd_flow),
        .err_underflow(err_underflow)
    );

    // Scoreboard entry: bit 3 = release, bits 2:0 = flow.
    logic [3:0] expq [$];
    longint     mcnt [NF];
    longint     mtot;
    bit         mheld [NF];
    int drv_checks = 0, drv_fails = 0, mon_checks = 0, mon_fails = 0;
    bit mon_on = 1'b0, done = 1'b0;

    // Monitor: one command per cycle, compared in order with the expectation queue (R8).
    always @(negedge clk) begin
        if (mon_on) begin
            mon_checks++;
            if (cmd_valid) begin
                if (expq.size() == 0) begin
                    mon_fails++;
                    $display("FAIL R6: unexpected command rel=%0d flow=%0d, expected none",
                             cmd_release, cmd_flow);
                end else begin
                    logic [3:0] e;
                    e = expq.pop_front();
                    if ({cmd_release, cmd_flow} !== e) begin
                        mon_fails++;
                        $display("FAIL R8: command rel=%0d flow=%0d, expected rel=%0d flow=%0d",
                                 cmd_release, cmd_flow, e[3], e[2:0]);
                    end
                end
            end else if (expq.size() != 0) begin
                mon_fails++;
                $display("FAIL R3: no command, expected rel=%0d flow=%0d",
                         expq[0][3], expq[0][2:0]);
            end
        end
    end

    function automatic longint upd(longint cur, longint inc, longint dec, inout bit err);
        longint s;
        s = cur + inc;
        if (s < dec) begin
            err = 1'b1;
            return 0;
        end
        s = s - dec;
        return (s > CAP) ? CAP : s;
    endfunction

    task automatic judge(int f, ref logic [3:0] pend [$]);
        if (!mheld[f] && (mcnt[f] >= xoff_lvl || mtot >= xoff_lvl)) begin
            mheld[f] = 1'b1;
            pend.push_back({1'b0, 3'(f)});
        end else if (mheld[f] && mcnt[f] <= xon_lvl && mtot <= xon_lvl) begin
            mheld[f] = 1'b0;
            pend.push_back({1'b1, 3'(f)});
        end
    endtask

    // Driver: called at a falling edge; applies one input cycle and checks err_underflow.
    task automatic cyc(bit av, int af, int al, bit dv, int df, int dl);
        logic [3:0] pend [$];
        bit eerr = 1'b0;
        arr_valid = av; arr_flow = 3'(af); arr_bytes = 20'(al);
        dep_valid = dv; dep_flow = 3'(df); dep_bytes = 20'(dl);
        for (int f = 0; f < NF; f++)
            mcnt[f] = upd(mcnt[f], (av && af == f) ? al : 0, (dv && df == f) ? dl : 0, eerr);
        mtot = upd(mtot, av ? al : 0, dv ? dl : 0, eerr);
        if (av) judge(af, pend);
        if (dv && !(av && df == af)) judge(df, pend);
        @(posedge clk);
        foreach (pend[i]) expq.push_back(pend[i]);
        @(negedge clk);
        drv_checks++;
        if (err_underflow !== eerr) begin
            drv_fails++;
            $display("FAIL R5: err_underflow=%0d, expected %0d", err_underflow, eerr);
        end
        arr_valid = 1'b0; dep_valid = 1'b0;
    endtask

    task automatic go(bit av, int af, int al, bit dv, int df, int dl);
        cyc(av, af, al, dv, df, dl);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int f = 0; f < NF; f++) begin mcnt[f] = 0; mheld[f] = 1'b0; end
        mtot = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drv_checks++; // R10
        if (cmd_valid !== 1'b0 || err_underflow !== 1'b0) begin
            drv_fails++;
            $display("FAIL R10: cmd_valid=%0d err=%0d, expected 0 0", cmd_valid, err_underflow);
        end
        mon_on = 1'b1;
        // R1 R3: flow counter reaches the hold level exactly by accumulation
        go(1, 0, 600, 0, 0, 0);
        go(1, 0, 400, 0, 0, 0);
        // R6: no repeat hold
        go(1, 0, 100, 0, 0, 0);
        // R2 R4: drain to exactly the release level
        go(0, 0, 0, 1, 0, 700);
        go(0, 0, 0, 1, 0, 400);
        // R3: total counter crossing
        go(1, 1, 500, 0, 0, 0);
        go(1, 2, 600, 0, 0, 0);
        // R4: release blocked by total; R9: untouched flow 2 stays held
        go(0, 0, 0, 1, 2, 600);
        go(0, 0, 0, 1, 1, 500);
        go(1, 2, 100, 1, 0, 100);
        go(0, 0, 0, 1, 0, 100);
        go(0, 0, 0, 1, 2, 100);
        // R7: same-flow arrival and departure merged
        go(1, 3, 900, 0, 0, 0);
        go(1, 3, 300, 1, 3, 250);
        go(1, 3, 50, 0, 0, 0);
        go(1, 3, 100, 1, 3, 700);
        go(0, 0, 0, 1, 3, 400);
        // R5: clamp at zero, then fill shows no wrap
        go(0, 0, 0, 1, 5, 50);
        go(1, 5, 1000, 0, 0, 0);
        go(0, 0, 0, 1, 5, 1000);
        // R8: two crossings in one cycle, arrival flow first
        go(1, 6, 300, 0, 0, 0);
        go(1, 7, 300, 0, 0, 0);
        go(1, 6, 800, 1, 7, 100);
        go(1, 7, 0, 1, 6, 1100);
        go(0, 0, 0, 1, 7, 200);
        // R3 R4: thresholds changed at run time
        xoff_lvl = 20'd200; xon_lvl = 20'd100;
        go(1, 1, 200, 0, 0, 0);
        go(0, 0, 0, 1, 1, 100);
        go(0, 0, 0, 1, 1, 100);
        mon_on = 1'b0;
        if (expq.size() != 0) begin
            drv_fails++;
            $display("FAIL R8: %0d commands never issued, expected 0", expq.size());
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==",
                 drv_checks + mon_checks, drv_fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==",
                     drv_checks + mon_checks + 1, drv_fails + mon_fails + 1);
            $finish;
        end
    end
endmodule